// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls 32-bit command words out of a circular buffer in memory and passes them to a downstream command consumer. Software sets four things: the buffer's start address, which is relative to a fixed memory region; its length; a head byte offset; and a tail byte offset. It then switches the engine on. From then on, software submits work only by moving the tail forward. The engine reads the word at head and moves head on by one dword each time. Head wraps back to zero at the end of the buffer, and reading continues until head meets tail.

Word sizes differ at the two pointers. Head moves in 4-byte steps. Tail can only point at 8-byte boundaries, so software pads an odd-length submission with an all-zero word. A word whose opcode field is zero is a no-op: the engine consumes it and does not forward it. If a no-op has a nonzero identifier in its low bits, that value is latched into a readable identification register. Software reads this register to confirm that the engine has reached a given point in the stream.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, every register reads zero: start, length, head, tail, control and no-op identifier. After reset `cmd_valid` and `mem_req` are low.
- R2: No memory read is issued while the engine is switched off, nor while head equals tail.
- R3: Each memory read addresses REGION_BASE + start + head, and that address lies inside the programmed buffer.
- R4: A forwarded word stays on `cmd_data`, with `cmd_valid` held high, until `cmd_ready` accepts it. Head advances by 4 only on that acceptance.
- R5: When head + 4 reaches the buffer length, head wraps to 0. Fetching continues from the start of the buffer.
- R6: Writes to tail and length drop the low 3 bits. Writes to head drop the low 2 bits.
- R7: A word with bits [31:23] all zero is a no-op. It is never forwarded, and head still advances past it.
- R8: A no-op whose bits [22:0] are nonzero loads those bits into the identifier register. A no-op with a zero identifier leaves the register unchanged.
- R9: Writing 1 to control bit 0 turns the engine on. It stays on until reset: writing 0 has no effect, and head writes are ignored while it is on.
- R10: Registers are at these offsets: start 0x2030, length 0x2034, head 0x2038, tail 0x203C, control 0x2040, identifier 0x2094. The identifier is read-only. Forwarded words keep the order in which they appear in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Consumer accepts command word |
| cmd_data | output | 32 | Command word |

## Verification
A wrong head value shows up at once, in two places: `mem_addr` on the next memory request, and the head register readback. It also later shows up as words that are missing, repeated or out of order at the command output. A broken wrap shows up within one buffer pass, as an address outside the buffer. Broken no-op handling shows up in the identifier register, or as a zero-opcode word on the output, when the next padded submission is drained. A stall that is handled wrongly shows up within a few cycles as a changed word or a moved head while `cmd_ready` is low.

// File: rtl/ring_pkg.sv
package ring_pkg;
   localparam int DW = 32;
   localparam int RAW = 16;

   localparam logic [RAW-1:0] RA_START = 16'h2030;
   localparam logic [RAW-1:0] RA_LEN   = 16'h2034;
   localparam logic [RAW-1:0] RA_HEAD  = 16'h2038;
   localparam logic [RAW-1:0] RA_TAIL  = 16'h203C;
   localparam logic [RAW-1:0] RA_CTRL  = 16'h2040;
   localparam logic [RAW-1:0] RA_NOPID = 16'h2094;

   typedef enum logic [1:0] {
      F_IDLE = 2'd0,
      F_REQ  = 2'd1,
      F_WAIT = 2'd2,
      F_OUT  = 2'd3
   } fetch_st_e;
endpackage

// File: rtl/ring_regfile.sv
module ring_regfile
   import ring_pkg::*;
#(
   parameter int AW  = 32,
   parameter int OW  = 16,
   parameter int IDW = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [RAW-1:0]      reg_addr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic [OW-1:0]       head_i,
   input  logic                id_load,
   input  logic [IDW-1:0]      id_val,
   output logic [AW-1:0]       start_o,
   output logic [OW-1:0]       len_o,
   output logic [OW-1:0]       tail_o,
   output logic                en_o,
   output logic                head_wr_o,
   output logic [OW-1:0]       head_wdata_o
);
   logic [AW-1:0]  start_q;
   logic [OW-1:0]  len_q, tail_q;
   logic           en_q;
   logic [IDW-1:0] id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         len_q   <= '0;
         tail_q  <= '0;
         en_q    <= 1'b0;
         id_q    <= '0;
      end else begin
         if (reg_we) begin
            unique case (reg_addr)
               RA_START: start_q <= {reg_wdata[AW-1:2], 2'b00};
               RA_LEN:   len_q   <= {reg_wdata[OW-1:3], 3'b000};
               RA_TAIL:  tail_q  <= {reg_wdata[OW-1:3], 3'b000};
               RA_CTRL:  if (reg_wdata[0]) en_q <= 1'b1;
               default: ;
            endcase
         end
         if (id_load) id_q <= id_val;
      end
   end

   assign head_wr_o    = reg_we && (reg_addr == RA_HEAD) && !en_q;
   assign head_wdata_o = {reg_wdata[OW-1:2], 2'b00};

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_START: reg_rdata = DW'(start_q);
         RA_LEN:   reg_rdata = DW'(len_q);
         RA_HEAD:  reg_rdata = DW'(head_i);
         RA_TAIL:  reg_rdata = DW'(tail_q);
         RA_CTRL:  reg_rdata = DW'(en_q);
         RA_NOPID: reg_rdata = DW'(id_q);
         default:  reg_rdata = '0;
      endcase
   end

   assign start_o = start_q;
   assign len_o   = len_q;
   assign tail_o  = tail_q;
   assign en_o    = en_q;
endmodule

// File: rtl/ring_nop_sniff.sv
module ring_nop_sniff
   import ring_pkg::*;
#(
   parameter int OPW       = 9,
   parameter bit NOP_ID_EN = 1'b1,
   localparam int IDW      = DW - OPW
) (
   input  logic [DW-1:0]  word,
   output logic           is_nop,
   output logic           id_hit,
   output logic [IDW-1:0] id
);
   assign is_nop = (word[DW-1:IDW] == '0);
   assign id     = word[IDW-1:0];

   generate
      if (NOP_ID_EN) begin : g_id
         assign id_hit = is_nop && (id != '0);
      end else begin : g_noid
         assign id_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
   import ring_pkg::*;
#(
   parameter int AW                = 32,
   parameter int OW                = 16,
   parameter int OPW               = 9,
   parameter bit NOP_ID_EN         = 1'b1,
   parameter logic [31:0] REGION_BASE = 32'h0010_0000,
   localparam int IDW              = DW - OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  start_i,
   input  logic [OW-1:0]  len_i,
   input  logic [OW-1:0]  tail_i,
   input  logic           en_i,
   input  logic           head_wr,
   input  logic [OW-1:0]  head_wdata,
   output logic [OW-1:0]  head_o,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata,
   output logic           cmd_valid,
   input  logic           cmd_ready,
   output logic [DW-1:0]  cmd_data,
   output logic           id_load,
   output logic [IDW-1:0] id_val
);
   fetch_st_e      st_q;
   logic [OW-1:0]  head_q;
   logic [DW-1:0]  data_q;
   logic [OW:0]    head_p4;
   logic [OW-1:0]  head_nx;
   logic           rd_nop, rd_hit;

   ring_nop_sniff #(.OPW(OPW), .NOP_ID_EN(NOP_ID_EN)) u_sniff (
      .word   (mem_rdata),
      .is_nop (rd_nop),
      .id_hit (rd_hit),
      .id     (id_val)
   );

   assign head_p4 = {1'b0, head_q} + (OW+1)'(4);
   assign head_nx = (head_p4 >= {1'b0, len_i}) ? '0 : head_p4[OW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         head_q <= '0;
         data_q <= '0;
      end else begin
         unique case (st_q)
            F_IDLE: begin
               if (head_wr)                        head_q <= head_wdata;
               else if (en_i && head_q != tail_i)  st_q   <= F_REQ;
            end
            F_REQ: st_q <= F_WAIT;
            F_WAIT: begin
               if (mem_rvalid) begin
                  data_q <= mem_rdata;
                  if (rd_nop) begin
                     head_q <= head_nx;
                     st_q   <= F_IDLE;
                  end else begin
                     st_q   <= F_OUT;
                  end
               end
            end
            F_OUT: begin
               if (cmd_ready) begin
                  head_q <= head_nx;
                  st_q   <= F_IDLE;
               end
            end
            default: st_q <= F_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q == F_REQ);
   assign mem_addr  = AW'(REGION_BASE) + start_i + AW'(head_q);
   assign cmd_valid = (st_q == F_OUT);
   assign cmd_data  = data_q;
   assign id_load   = (st_q == F_WAIT) && mem_rvalid && rd_hit;
   assign head_o    = head_q;
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import ring_pkg::*;
#(
   parameter int AW                   = 32,
   parameter int OW                   = 16,
   parameter int OPW                  = 9,
   parameter bit NOP_ID_EN            = 1'b1,
   parameter logic [31:0] REGION_BASE = 32'h0010_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [15:0]     reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic            mem_req,
   output logic [31:0]     mem_addr,
   input  logic            mem_rvalid,
   input  logic [31:0]     mem_rdata,
   output logic            cmd_valid,
   input  logic            cmd_ready,
   output logic [31:0]     cmd_data
);
   localparam int IDW = DW - OPW;

   generate
      if (AW != 32) begin : g_bad_aw
         $error("cmd_ring_fetch: AW must be 32");
      end
      if (OW < 4 || OW > AW) begin : g_bad_ow
         $error("cmd_ring_fetch: OW out of range");
      end
      if (OPW < 1 || OPW > 16) begin : g_bad_opw
         $error("cmd_ring_fetch: OPW out of range");
      end
   endgenerate

   logic [AW-1:0]  start_w;
   logic [OW-1:0]  len_w, tail_w, head_w, head_wd_w;
   logic           en_w, head_wr_w, id_load_w;
   logic [IDW-1:0] id_val_w;
   logic [AW-1:0]  mem_addr_w;

   ring_regfile #(.AW(AW), .OW(OW), .IDW(IDW)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .head_i       (head_w),
      .id_load      (id_load_w),
      .id_val       (id_val_w),
      .start_o      (start_w),
      .len_o        (len_w),
      .tail_o       (tail_w),
      .en_o         (en_w),
      .head_wr_o    (head_wr_w),
      .head_wdata_o (head_wd_w)
   );

   ring_fetch #(
      .AW(AW), .OW(OW), .OPW(OPW), .NOP_ID_EN(NOP_ID_EN), .REGION_BASE(REGION_BASE)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .len_i      (len_w),
      .tail_i     (tail_w),
      .en_i       (en_w),
      .head_wr    (head_wr_w),
      .head_wdata (head_wd_w),
      .head_o     (head_w),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr_w),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_data   (cmd_data),
      .id_load    (id_load_w),
      .id_val     (id_val_w)
   );

   assign mem_addr = mem_addr_w;
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
   parameter int OW  = 16,
   parameter int OPW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [31:0]   cmd_data,
   input logic          mem_req,
   input logic          en,
   input logic          head_wr,
   input logic [OW-1:0] head,
   input logic [OW-1:0] tail
);
   // R4: offered word held until accepted
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

   // R4: head frozen during a stall
   p_head_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> $stable(head));

   // R7: no-op never reaches the output
   p_no_nop_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_data[31:32-OPW] != '0);

   // R2: reads only when enabled and not empty
   p_empty_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> en && (head != tail));

   // R5: head moves by one dword or wraps to zero
   p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(head) && !$past(head_wr) |-> (head == $past(head) + OW'(4)) || (head == '0));

   // R9: head writes land only while disabled
   p_head_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      head_wr |-> !en);
endmodule

bind cmd_ring_fetch ring_fetch_chk #(.OW(OW), .OPW(OPW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_data  (cmd_data),
   .mem_req   (mem_req),
   .en        (en_w),
   .head_wr   (head_wr_w),
   .head      (head_w),
   .tail      (tail_w)
);

// File: tb/sim_cmd_ring_fetch.sv
`timescale 1ns/1ps
module sim_cmd_ring_fetch;
   localparam logic [31:0] BASE  = 32'h0010_0000;
   localparam logic [31:0] START = 32'h40;
   localparam int          LEN   = 32'h20;
   localparam logic [15:0] A_START = 16'h2030, A_LEN = 16'h2034, A_HEAD = 16'h2038,
                           A_TAIL = 16'h203C, A_CTRL = 16'h2040, A_ID = 16'h2094;

   logic clk = 0, rst_n = 0;
   logic reg_we = 0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req, mem_rvalid = 0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic cmd_valid, cmd_ready = 0;
   logic [31:0] cmd_data;

   int checks = 0, errors = 0;
   bit stall = 0, done = 0;
   int pat = 0;
   logic [31:0] mem [0:63];
   logic [31:0] exp_q[$], got_q[$];
   logic [22:0] exp_id = '0;
   int mtail = 0;
   logic [31:0] rd;

   always #4 clk = ~clk;

   cmd_ring_fetch u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
   );

   always @(posedge clk) begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem[6'((mem_addr - BASE) >> 2)];
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cmd_ready = stall ? 1'b0 : ((pat % 3) != 0);
      pat++;
      if (cmd_valid && cmd_ready) got_q.push_back(cmd_data);
      if (rst_n && mem_req) begin
         // R3: address inside the buffer and dword aligned
         check(mem_addr >= BASE + START && mem_addr < BASE + START + LEN && mem_addr[1:0] == 2'b00,
               "R3 mem_addr in buffer", mem_addr, BASE + START);
      end
   end

   task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic submit(input int n, input logic [31:0] w [8]);
      for (int i = 0; i < n; i++) begin
         mem[16 + mtail/4] = w[i];
         if (w[i][31:23] != 0) exp_q.push_back(w[i]);
         else if (w[i][22:0] != 0) exp_id = w[i][22:0];
         mtail = (mtail + 4) % LEN;
      end
      reg_write(A_TAIL, 32'(mtail));
   endtask

   task automatic drain(input string tag);
      int k;
      k = 0;
      do begin
         reg_read(A_HEAD, rd);
         k++;
      end while ((rd != 32'(mtail) || got_q.size() != exp_q.size()) && k < 400);
      check(rd == 32'(mtail), {tag, " head reaches tail"}, rd, 32'(mtail));
      check(got_q.size() == exp_q.size(), {tag, " forwarded count"}, 32'(got_q.size()), 32'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], {tag, " R10 word order"}, got_q[i], exp_q[i]);
      got_q.delete(); exp_q.delete();
   endtask

   initial begin
      #(8*150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] w [8];
      bit req_seen;
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check(!cmd_valid && !mem_req, "R1 outputs idle", {30'd0, cmd_valid, mem_req}, 0);
      reg_read(A_START, rd); check(rd == 0, "R1 start", rd, 0);
      reg_read(A_LEN, rd);   check(rd == 0, "R1 length", rd, 0);
      reg_read(A_HEAD, rd);  check(rd == 0, "R1 head", rd, 0);
      reg_read(A_TAIL, rd);  check(rd == 0, "R1 tail", rd, 0);
      reg_read(A_CTRL, rd);  check(rd == 0, "R1 control", rd, 0);
      reg_read(A_ID, rd);    check(rd == 0, "R1 identifier", rd, 0);

      reg_write(A_START, START);
      reg_write(A_LEN, 32'(LEN) | 32'h5);
      reg_read(A_LEN, rd); check(rd == 32'(LEN), "R6 length low bits", rd, LEN);
      reg_write(A_TAIL, 32'h0F);
      reg_read(A_TAIL, rd); check(rd == 32'h08, "R6 tail low bits", rd, 32'h08);
      reg_write(A_HEAD, 32'h13);
      reg_read(A_HEAD, rd); check(rd == 32'h10, "R6 head low bits", rd, 32'h10);
      reg_write(A_HEAD, 0);
      // R2: disabled with head != tail
      req_seen = 0;
      repeat (12) begin @(negedge clk); if (mem_req) req_seen = 1; end
      check(!req_seen, "R2 no read while disabled", 32'(req_seen), 0);
      reg_write(A_TAIL, 0);
      reg_write(A_CTRL, 1);
      reg_read(A_CTRL, rd); check(rd == 1, "R9 enable set", rd, 1);
      req_seen = 0;
      repeat (12) begin @(negedge clk); if (mem_req) req_seen = 1; end
      check(!req_seen, "R2 no read while empty", 32'(req_seen), 0);

      // S1: one command plus padding
      w = '{32'h1000_0001, 32'h0, 0, 0, 0, 0, 0, 0};
      submit(2, w); drain("S1 R7");
      // S2: identified no-op, two commands, pad
      w = '{32'h0000_0123, 32'h2000_0002, 32'h2000_0003, 32'h0, 0, 0, 0, 0};
      submit(4, w); drain("S2 R4");
      reg_read(A_ID, rd); check(rd == 32'(exp_id), "R8 identifier load", rd, 32'(exp_id));
      // S3: wraps past end of buffer
      w = '{32'h3000_0004, 32'h007F_FFFF, 32'h0080_0000, 32'h0, 0, 0, 0, 0};
      submit(4, w); drain("S3 R5 wrap");
      reg_read(A_HEAD, rd); check(rd == 32'h08, "R5 head after wrap", rd, 32'h08);
      reg_read(A_ID, rd); check(rd == 32'h007F_FFFF, "R8 zero-id no-op keeps value", rd, 32'h007F_FFFF);

      // S4: stalled consumer
      stall = 1;
      w = '{32'h4000_0006, 32'h0, 0, 0, 0, 0, 0, 0};
      submit(2, w);
      repeat (20) @(negedge clk);
      #1;
      check(cmd_valid && cmd_data == 32'h4000_0006, "R4 word held under stall", cmd_data, 32'h4000_0006);
      reg_read(A_HEAD, rd); check(rd == 32'h08, "R4 head frozen under stall", rd, 32'h08);
      stall = 0;
      drain("S4 R4");

      // R9: enable sticky, head writes ignored
      reg_write(A_CTRL, 0);
      reg_read(A_CTRL, rd); check(rd == 1, "R9 enable sticky", rd, 1);
      reg_write(A_HEAD, 32'h04);
      reg_read(A_HEAD, rd); check(rd == 32'(mtail), "R9 head write ignored", rd, 32'(mtail));
      req_seen = 0;
      repeat (12) begin @(negedge clk); if (mem_req) req_seen = 1; end
      check(!req_seen, "R9 no fetch after ignored head write", 32'(req_seen), 0);

      // long run: several passes around the ring
      for (int r = 0; r < 6; r++) begin
         w = '{32'h5000_0000 | 32'(r), 32'h0000_0010 + 32'(r), 32'h5100_0000 | 32'(r), 32'h0,
               0, 0, 0, 0};
         submit(4, w); drain("loop R5 R8");
      end
      reg_read(A_ID, rd); check(rd == 32'(exp_id), "R8 identifier after loop", rd, 32'(exp_id));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule